// File: doc/BRIEF.md
# Sensor Register Bank with Coherent Sample Readout

This block is the register file behind a digital sensor's serial slave port. A generic bus front end hands it a start address and then a series of byte strobes, each either a write carrying a data byte or a read that takes the byte on `bus_rdata`. The bank holds two control registers and a three-byte output sample. A measurement engine fills the sample through a valid strobe.

The first control register selects the block-update behaviour and the extra low-pass filter setting. From the filter setting the bank decodes a bandwidth code for the filter datapath. The second control register holds enables and three command bits: reload trim values, software reset and single acquisition. Each command bit raises a request line. The bit stays set until the matching operation reports that it is complete, and then it clears itself.

With block update enabled, the output bytes freeze as soon as a sample is latched. They stay frozen until the host reads the most significant byte, so a multi-byte read never mixes two samples. A sample that arrives during the freeze waits in a one-deep holding slot.

Top module: `sensor_regbank`

## Requirements
- R1: After reset, the register at 0x11 reads 0x10, the register at 0x10 reads 0x00, the sample bytes at 0x28..0x2A read 0x00, and all three request outputs are low.
- R2: When bit 4 of 0x11 (auto-increment) is 1, each read or write strobe advances the byte address by one. The address wraps from 0x7F to 0x00.
- R3: When auto-increment is 0, successive strobes all access the start address.
- R4: Bit 1 of 0x11 is reserved. Writes to it are ignored and it always reads 0.
- R5: `bw_sel` is 0 (ODR/2) when bit 2 of 0x10 (filter enable) is 0, whatever the value of bit 1. It is 1 (ODR/9) when bit 2 is 1 and bit 1 is 0. It is 2 (ODR/20) when both bits are 1.
- R6: With bit 0 of 0x10 (block update) at 0, every `sample_valid` writes the whole sample into 0x28 (low byte), 0x29 and 0x2A (high byte).
- R7: With block update at 1, the sample bytes stay unchanged after a sample is latched. They are released by a read strobe at 0x2A, and the next sample then updates them.
- R8: A sample that arrives during a freeze is held, and a later one overwrites it. On release, the held sample is copied to the output, and that copy freezes the output again.
- R9: Writing 1 to bit 7 of 0x11 raises `boot_req`. The bit clears on `boot_done`. Writing 0 while the bit is set does not clear it.
- R10: Writing 1 to bit 2 of 0x11 raises `swrst_req`. On `swrst_done`, both control registers return to their reset values.
- R11: Writing 1 to bit 0 of 0x11 raises `oneshot_req`. The bit clears when the next `sample_valid` arrives.
- R12: Reads of any address other than 0x10, 0x11 and 0x28..0x2A return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | Load the start address; strobes in the same cycle are ignored |
| bus_addr | input | 7 | Start address |
| bus_wr | input | 1 | Write strobe for one byte |
| bus_wdata | input | 8 | Write byte |
| bus_rd | input | 1 | Read strobe; the byte is consumed at this edge |
| bus_rdata | output | 8 | Byte at the current address |
| sample_valid | input | 1 | New sample from the measurement engine |
| sample_data | input | 24 | Sample value |
| boot_req | output | 1 | Trim reload requested |
| boot_done | input | 1 | Trim reload complete |
| swrst_req | output | 1 | Software reset requested |
| swrst_done | input | 1 | Software reset complete |
| oneshot_req | output | 1 | Single acquisition requested |
| fifo_en | output | 1 | Sample queue enable |
| stop_on_thr | output | 1 | Stop at queue threshold |
| i2c_off | output | 1 | Two-wire port disable |
| bw_sel | output | 2 | Filter bandwidth code |

## Verification
A wrong freeze or holding-slot state does not show at once. It appears at the next read sequence at 0x28..0x2A, as bytes from a stale, skipped or mixed sample. A command bit stuck high shows on its request output one cycle after the done strobe, and also on the next read of 0x11. A slipped address counter shows on the very next read byte, as a wrong register value or 0x00.

// File: rtl/sensor_regbank_pkg.sv
package sensor_regbank_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] ADDR_CTRL1    = 7'h10;
  localparam logic [ADDR_W-1:0] ADDR_CTRL2    = 7'h11;
  localparam logic [ADDR_W-1:0] ADDR_OUT_BASE = 7'h28;

  // control register 2 bit positions
  localparam int C2_BOOT  = 7;
  localparam int C2_FIFO  = 6;
  localparam int C2_STOP  = 5;
  localparam int C2_INC   = 4;
  localparam int C2_I2C   = 3;
  localparam int C2_SWRST = 2;
  localparam int C2_RSV   = 1;
  localparam int C2_ONE   = 0;

  localparam logic [DATA_W-1:0] CTRL2_DEFAULT = 8'h10;
  localparam logic [DATA_W-1:0] CMD_MASK      = 8'h85;
  localparam logic [DATA_W-1:0] RSV_MASK      = 8'h02;

  typedef struct packed {
    logic lpf_en;
    logic lpf_cfg;
    logic bdu;
  } ctrl1_t;

  typedef enum logic [1:0] {
    BW_DIV2  = 2'd0,
    BW_DIV9  = 2'd1,
    BW_DIV20 = 2'd2
  } bw_sel_e;
endpackage

// File: rtl/sr_addr_ctr.sv
module sr_addr_ctr #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          step,
  input  logic          auto_inc,
  output logic [AW-1:0] addr_q
);
  logic [AW-1:0] addr_d;
  logic          addr_en;

  always_comb begin
    addr_en = 1'b0;
    addr_d  = addr_q;
    if (start) begin
      addr_en = 1'b1;
      addr_d  = start_addr;
    end else if (step && auto_inc) begin
      addr_en = 1'b1;
      addr_d  = addr_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && auto_inc && !start) |=> (addr_q == $past(addr_q) + AW'(1)));
  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !auto_inc && !start) |=> $stable(addr_q));
endmodule

// File: rtl/sr_ctrl_regs.sv
module sr_ctrl_regs
  import sensor_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl1,
  input  logic              wr_ctrl2,
  input  logic [DATA_W-1:0] wdata,
  input  logic              boot_done,
  input  logic              swrst_done,
  input  logic              sample_valid,
  output ctrl1_t            ctrl1_q,
  output logic [DATA_W-1:0] ctrl2_q
);
  ctrl1_t            ctrl1_d;
  logic [DATA_W-1:0] ctrl2_d;
  logic              ctrl_en;

  always_comb begin
    ctrl1_d = ctrl1_q;
    ctrl2_d = ctrl2_q;
    if (wr_ctrl1) ctrl1_d = ctrl1_t'(wdata[2:0]);
    if (wr_ctrl2)
      // command bits are set-only from the bus; plain bits take the byte
      ctrl2_d = (wdata & ~CMD_MASK) | ((wdata | ctrl2_q) & CMD_MASK);
    if (boot_done)    ctrl2_d[C2_BOOT] = 1'b0;
    if (sample_valid) ctrl2_d[C2_ONE]  = 1'b0;
    if (swrst_done) begin
      ctrl1_d = '0;
      ctrl2_d = CTRL2_DEFAULT;
    end
    ctrl2_d = ctrl2_d & ~RSV_MASK;
    ctrl_en = wr_ctrl1 | wr_ctrl2 | boot_done | sample_valid | swrst_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl1_q <= '0;
      ctrl2_q <= CTRL2_DEFAULT;
    end else if (ctrl_en) begin
      ctrl1_q <= ctrl1_d;
      ctrl2_q <= ctrl2_d;
    end
  end

  // R9
  boot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> !ctrl2_q[C2_BOOT]);
  // R9
  boot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl2_q[C2_BOOT] && !boot_done && !swrst_done) |=> ctrl2_q[C2_BOOT]);
  // R11
  oneshot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && !wr_ctrl2) |=> !ctrl2_q[C2_ONE]);
  // R10
  swrst_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_done |=> (ctrl2_q == CTRL2_DEFAULT && ctrl1_q == '0));
endmodule

// File: rtl/sr_out_bdu.sv
module sr_out_bdu #(
  parameter int NB = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bdu,
  input  logic            sample_valid,
  input  logic [NB*8-1:0] sample_data,
  input  logic            release_rd,
  output logic [NB*8-1:0] out_q,
  output logic            frozen_q
);
  localparam int SW = NB * 8;

  logic [SW-1:0] pend_q, pend_d, out_d;
  logic          pend_v_q, pend_v_d, frozen_d;
  logic          out_en, pend_en, still_frozen;

  always_comb begin
    out_d        = out_q;
    out_en       = 1'b0;
    pend_d       = pend_q;
    pend_en      = 1'b0;
    pend_v_d     = pend_v_q;
    frozen_d     = frozen_q;
    still_frozen = frozen_q && !release_rd;
    if (!bdu) begin
      frozen_d = 1'b0;
      pend_v_d = 1'b0;
      if (sample_valid) begin
        out_d  = sample_data;
        out_en = 1'b1;
      end else if (pend_v_q) begin
        out_d  = pend_q;
        out_en = 1'b1;
      end
    end else if (sample_valid) begin
      if (still_frozen) begin
        pend_d   = sample_data;
        pend_en  = 1'b1;
        pend_v_d = 1'b1;
      end else begin
        out_d    = sample_data;
        out_en   = 1'b1;
        frozen_d = 1'b1;
        pend_v_d = 1'b0;
      end
    end else if (frozen_q && release_rd) begin
      if (pend_v_q) begin
        out_d    = pend_q;
        out_en   = 1'b1;
        frozen_d = 1'b1;
        pend_v_d = 1'b0;
      end else begin
        frozen_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else if (out_en) out_q <= out_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q <= 1'b0;
      frozen_q <= 1'b0;
    end else begin
      pend_v_q <= pend_v_d;
      frozen_q <= frozen_d;
    end
  end

  // R7
  frozen_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bdu && frozen_q && !release_rd) |=> $stable(out_q));
  // R6
  direct_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bdu && sample_valid) |=> (out_q == $past(sample_data)));
  // R8
  pend_only_when_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v_q |-> frozen_q);
endmodule

// File: rtl/sensor_regbank.sv
module sensor_regbank
  import sensor_regbank_pkg::*;
#(
  parameter int SAMPLE_BYTES = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_start,
  input  logic [6:0]              bus_addr,
  input  logic                    bus_wr,
  input  logic [7:0]              bus_wdata,
  input  logic                    bus_rd,
  output logic [7:0]              bus_rdata,
  input  logic                    sample_valid,
  input  logic [SAMPLE_BYTES*8-1:0] sample_data,
  output logic                    boot_req,
  input  logic                    boot_done,
  output logic                    swrst_req,
  input  logic                    swrst_done,
  output logic                    oneshot_req,
  output logic                    fifo_en,
  output logic                    stop_on_thr,
  output logic                    i2c_off,
  output logic [1:0]              bw_sel
);
  localparam logic [ADDR_W-1:0] ADDR_OUT_TOP = ADDR_OUT_BASE + ADDR_W'(SAMPLE_BYTES - 1);

  logic [ADDR_W-1:0]         addr_q;
  logic                      step, wr_ctrl1, wr_ctrl2, release_rd, frozen_q;
  ctrl1_t                    ctrl1_q;
  logic [DATA_W-1:0]         ctrl2_q;
  logic [SAMPLE_BYTES*8-1:0] out_q;
  logic [DATA_W-1:0]         out_byte [SAMPLE_BYTES];

  assign step       = (bus_wr | bus_rd) && !bus_start;
  assign wr_ctrl1   = bus_wr && !bus_start && (addr_q == ADDR_CTRL1);
  assign wr_ctrl2   = bus_wr && !bus_start && (addr_q == ADDR_CTRL2);
  assign release_rd = bus_rd && !bus_start && (addr_q == ADDR_OUT_TOP);

  sr_addr_ctr #(.AW(ADDR_W)) addr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (bus_start),
    .start_addr (bus_addr),
    .step       (step),
    .auto_inc   (ctrl2_q[C2_INC]),
    .addr_q     (addr_q)
  );

  sr_ctrl_regs ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_ctrl1     (wr_ctrl1),
    .wr_ctrl2     (wr_ctrl2),
    .wdata        (bus_wdata),
    .boot_done    (boot_done),
    .swrst_done   (swrst_done),
    .sample_valid (sample_valid),
    .ctrl1_q      (ctrl1_q),
    .ctrl2_q      (ctrl2_q)
  );

  sr_out_bdu #(.NB(SAMPLE_BYTES)) out_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bdu          (ctrl1_q.bdu),
    .sample_valid (sample_valid),
    .sample_data  (sample_data),
    .release_rd   (release_rd),
    .out_q        (out_q),
    .frozen_q     (frozen_q)
  );

  for (genvar gi = 0; gi < SAMPLE_BYTES; gi++) begin : g_slice
    assign out_byte[gi] = out_q[gi*8 +: 8];
  end

  always_comb begin
    bus_rdata = '0;
    if (addr_q == ADDR_CTRL1) bus_rdata = {5'b0, ctrl1_q};
    else if (addr_q == ADDR_CTRL2) bus_rdata = ctrl2_q;
    for (int i = 0; i < SAMPLE_BYTES; i++)
      if (addr_q == ADDR_OUT_BASE + ADDR_W'(i)) bus_rdata = out_byte[i];
  end

  always_comb begin
    if (!ctrl1_q.lpf_en)     bw_sel = BW_DIV2;
    else if (ctrl1_q.lpf_cfg) bw_sel = BW_DIV20;
    else                     bw_sel = BW_DIV9;
  end

  assign boot_req    = ctrl2_q[C2_BOOT];
  assign swrst_req   = ctrl2_q[C2_SWRST];
  assign oneshot_req = ctrl2_q[C2_ONE];
  assign fifo_en     = ctrl2_q[C2_FIFO];
  assign stop_on_thr = ctrl2_q[C2_STOP];
  assign i2c_off     = ctrl2_q[C2_I2C];

  // R4
  rsv_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q == ADDR_CTRL2) |-> !bus_rdata[C2_RSV]);
  // R5
  bw_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bw_sel != 2'd3) && (ctrl1_q.lpf_en || bw_sel == 2'd0));
  // R12
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q != ADDR_CTRL1 && addr_q != ADDR_CTRL2 &&
     (addr_q < ADDR_OUT_BASE || addr_q > ADDR_OUT_TOP)) |-> (bus_rdata == 8'h00));
endmodule

// File: tb/sensor_regbank_tb.sv
`timescale 1ns/1ps
module sensor_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_start, bus_wr, bus_rd;
  logic [6:0]  bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        sample_valid, boot_done, swrst_done;
  logic [23:0] sample_data;
  logic        boot_req, swrst_req, oneshot_req, fifo_en, stop_on_thr, i2c_off;
  logic [1:0]  bw_sel;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  sensor_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .sample_valid(sample_valid), .sample_data(sample_data),
    .boot_req(boot_req), .boot_done(boot_done), .swrst_req(swrst_req),
    .swrst_done(swrst_done), .oneshot_req(oneshot_req), .fifo_en(fifo_en),
    .stop_on_thr(stop_on_thr), .i2c_off(i2c_off), .bw_sel(bw_sel)
  );

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic go(input logic [6:0] a);
    @(negedge clk); bus_start = 1'b1; bus_addr = a;
    @(negedge clk); bus_start = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(output logic [7:0] d);
    @(negedge clk); d = bus_rdata; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic rd_sample(output logic [23:0] s);
    logic [7:0] b0, b1, b2;
    go(7'h28); rd(b0); rd(b1); rd(b2);
    s = {b2, b1, b0};
  endtask

  task automatic push(input logic [23:0] s);
    @(negedge clk); sample_valid = 1'b1; sample_data = s;
    @(negedge clk); sample_valid = 1'b0;
  endtask

  task automatic read_reg(input logic [6:0] a, output logic [7:0] d);
    go(a); rd(d);
  endtask

  task automatic write_reg(input logic [6:0] a, input logic [7:0] d);
    go(a); wr(d);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    logic [23:0] s;
    chk({boot_req, swrst_req, oneshot_req}, 3'b000, "R1 request lines");
    read_reg(7'h11, d); chk(d, 8'h10, "R1 ctrl2 default");
    read_reg(7'h10, d); chk(d, 8'h00, "R1 ctrl1 default");
    rd_sample(s); chk(s, 24'h0, "R1 sample default");
  endtask

  task automatic t_autoinc;
    logic [7:0] a, b;
    go(7'h10); wr(8'h07); wr(8'h18);
    go(7'h10); rd(a); rd(b);
    chk(a, 8'h07, "R2 inc write ctrl1");
    chk(b, 8'h18, "R2 inc write ctrl2");
    chk(i2c_off, 1'b1, "R2 ctrl2 field out");
    write_reg(7'h11, 8'h10);
  endtask

  task automatic t_noinc;
    logic [7:0] a, b, c;
    write_reg(7'h11, 8'h00);
    go(7'h11); wr(8'h40); wr(8'h60);
    go(7'h11); rd(a); rd(b);
    chk(a, 8'h60, "R3 fixed address write");
    chk(b, 8'h60, "R3 fixed address read");
    write_reg(7'h11, 8'h10);
    read_reg(7'h11, c); chk(c, 8'h10, "R3 restore");
  endtask

  task automatic t_reserved;
    logic [7:0] d;
    write_reg(7'h11, 8'h12);
    read_reg(7'h11, d); chk(d, 8'h10, "R4 reserved bit ignored");
  endtask

  task automatic t_bw;
    write_reg(7'h10, 8'h02); @(negedge clk); chk(bw_sel, 2'd0, "R5 filter off cfg1");
    write_reg(7'h10, 8'h00); @(negedge clk); chk(bw_sel, 2'd0, "R5 filter off cfg0");
    write_reg(7'h10, 8'h04); @(negedge clk); chk(bw_sel, 2'd1, "R5 filter on cfg0");
    write_reg(7'h10, 8'h06); @(negedge clk); chk(bw_sel, 2'd2, "R5 filter on cfg1");
    write_reg(7'h10, 8'h00);
  endtask

  task automatic t_direct;
    logic [23:0] s;
    push(24'hA1B2C3); rd_sample(s); chk(s, 24'hA1B2C3, "R6 first sample");
    push(24'h112233); push(24'h445566);
    rd_sample(s); chk(s, 24'h445566, "R6 latest sample");
  endtask

  task automatic t_bdu;
    logic [7:0] b0, b1, b2;
    logic [23:0] s;
    write_reg(7'h10, 8'h01);
    push(24'h010203);
    go(7'h28); rd(b0);
    push(24'h0A0B0C);
    push(24'h0D0E0F);
    rd(b1); rd(b2);
    chk({b2, b1, b0}, 24'h010203, "R7 frozen bytes coherent");
    rd_sample(s); chk(s, 24'h0D0E0F, "R8 held sample overwritten and copied");
    push(24'h777777);
    rd_sample(s); chk(s, 24'h777777, "R7 update after release");
    push(24'h888888);
    go(7'h28); rd(b0); rd(b1);
    push(24'h999999);
    go(7'h28); rd(b0);
    chk(b0, 8'h88, "R7 low byte read does not release");
    write_reg(7'h10, 8'h00);
    rd_sample(s); chk(s, 24'h999999, "R8 held sample flushed when block update off");
  endtask

  task automatic t_boot;
    logic [7:0] d;
    write_reg(7'h11, 8'h90);
    repeat (3) @(negedge clk);
    chk(boot_req, 1'b1, "R9 boot request held");
    write_reg(7'h11, 8'h10);
    read_reg(7'h11, d); chk(d, 8'h90, "R9 write 0 does not cancel");
    @(negedge clk); boot_done = 1'b1; @(negedge clk); boot_done = 1'b0;
    chk(boot_req, 1'b0, "R9 self clear");
  endtask

  task automatic t_swrst;
    logic [7:0] d;
    write_reg(7'h10, 8'h07);
    write_reg(7'h11, 8'h44);
    chk(swrst_req, 1'b1, "R10 request raised");
    chk(fifo_en, 1'b1, "R10 field set before reset");
    @(negedge clk); swrst_done = 1'b1; @(negedge clk); swrst_done = 1'b0;
    chk(swrst_req, 1'b0, "R10 self clear");
    read_reg(7'h11, d); chk(d, 8'h10, "R10 ctrl2 default");
    read_reg(7'h10, d); chk(d, 8'h00, "R10 ctrl1 default");
  endtask

  task automatic t_oneshot;
    logic [7:0] d;
    write_reg(7'h11, 8'h11);
    read_reg(7'h11, d); chk(d, 8'h11, "R11 bit set");
    chk(oneshot_req, 1'b1, "R11 request raised");
    push(24'h123456);
    chk(oneshot_req, 1'b0, "R11 clear on sample");
  endtask

  task automatic t_wrap;
    logic [7:0] d;
    go(7'h7F);
    for (int k = 0; k < 19; k++) begin
      rd(d);
      if (k == 17)      chk(d, 8'h00, "R2 wrap reaches ctrl1");
      else if (k == 18) chk(d, 8'h10, "R2 wrap reaches ctrl2");
      else if (k == 0 || k == 5) chk(d, 8'h00, "R12 unmapped reads zero");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_start = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    bus_rd = 1'b0; sample_valid = 1'b0; sample_data = '0;
    boot_done = 1'b0; swrst_done = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_autoinc;
    t_noinc;
    t_reserved;
    t_bw;
    t_direct;
    t_bdu;
    t_boot;
    t_swrst;
    t_oneshot;
    t_wrap;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule